// File: doc/BRIEF.md
# Event Status and Mask Interrupt Aggregator

This block gathers single-cycle event pulses from up to 96 peripheral sources into three 32-bit sticky status words. Three independent mask groups each cover all three status words. Each group drives one interrupt request line towards the processor. Group 0 feeds the most urgent line, group 1 the middle one and group 2 the least urgent one. A line is raised when any event that is both pending and enabled in its group is present. Software clears a pending event by writing a one back to its status bit.

Software reaches the block through a plain 32-bit register port with a word address, a write strobe, write data and combinational read data. To identify the cause of an interrupt, software writes a line number to a selector register. It then reads a vector register, which returns the lowest-numbered event that is pending and enabled for that line.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every status word, every mask word and the line selector read as zero, the vector reads as zero, and `irq_o` is 3'b000.
- R2: An event pulse on `evt_i[n]` sets bit n%32 of the status word at byte offset 0x00, 0x04 or 0x08, chosen by word index n/32. The bit stays set until software clears it.
- R3: A write to a status word clears each bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: Mask word w of group g is read/write at byte offset 0x10·(g+1) + 4·w, for g and w in 0..2. A mask bit of 1 enables the matching event for that group.
- R6: `irq_o[g]` equals the OR over all three words of (status AND mask of group g). The output is registered, so it reflects a status or mask change one clock after the edge that made the change.
- R7: Clearing a mask bit removes that event from its group's line and vector. It leaves the status bit unchanged.
- R8: The line selector is written at offset 0x44, bits 1:0. A read of offset 0x40 returns bit 31 = 1 and, in bits 6:0, the lowest event number 32·w + b whose status and selected-group mask bits are both set. Event numbers are scanned upward from 0.
- R9: The vector read returns all zeros when the selected line has nothing pending, or when the selector holds 3.
- R10: A read of offset 0x44 returns the selector in bits 1:0. A read of any offset that is not mapped returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 96 | Event pulses; bit n is event number n |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 3 | Interrupt lines; bit 0 is driven by mask group 0 |

## Verification
A new event pulse and a software clear can land on the same status bit in the same cycle. The bench provokes this by raising an event bit on the same falling edge that starts a write of ones to that bit's status word. It then reads the word back and expects the bit to be still set. A second write with no event present must clear the bit, and the matching interrupt line must fall one clock later. Both results are judged against the bench's own status model.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam logic [ADDR_W-1:0] VEC_ADDR = 8'h40;
  localparam logic [ADDR_W-1:0] SEL_ADDR = 8'h44;

  // byte offset of status word w
  function automatic logic [ADDR_W-1:0] stat_addr(input int w);
    return ADDR_W'(4 * w);
  endfunction

  // byte offset of mask word w inside group g
  function automatic logic [ADDR_W-1:0] mask_addr(input int g, input int w);
    return ADDR_W'(16 * (g + 1) + 4 * w);
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int NWORD = 3,
  parameter int WBITS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWORD*WBITS-1:0] evt_i,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [WBITS-1:0]       wr_data,
  output logic [NWORD*WBITS-1:0] status_o,
  output logic [NWORD*WBITS-1:0] clr_o
);
  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic             hit;
    logic [WBITS-1:0] st_q;
    assign hit = wr_en && (wr_addr == evt_irq_pkg::stat_addr(w));
    assign clr_o[w*WBITS +: WBITS] = hit ? wr_data : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      // a fresh event outranks a clear of the same bit
      else st_q <= (st_q & ~clr_o[w*WBITS +: WBITS]) | evt_i[w*WBITS +: WBITS];
    end
    assign status_o[w*WBITS +: WBITS] = st_q;
  end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int NLINE = 3,
  parameter int NWORD = 3,
  parameter int WBITS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_addr,
  input  logic [WBITS-1:0]             wr_data,
  output logic [NLINE*NWORD*WBITS-1:0] mask_o
);
  localparam int GSPAN = NWORD * WBITS;
  for (genvar g = 0; g < NLINE; g++) begin : g_grp
    for (genvar w = 0; w < NWORD; w++) begin : g_word
      logic             hit;
      logic [WBITS-1:0] mk_q;
      assign hit = wr_en && (wr_addr == evt_irq_pkg::mask_addr(g, w));
      always_ff @(posedge clk) begin
        if (!rst_n)   mk_q <= '0;
        else if (hit) mk_q <= wr_data;
      end
      assign mask_o[g*GSPAN + w*WBITS +: WBITS] = mk_q;
    end
  end
endmodule

// File: rtl/evt_line_resolver.sv
module evt_line_resolver #(
  parameter int NLINE = 3,
  parameter int NWORD = 3,
  parameter int WBITS = 32,
  parameter int SELW  = 2,
  parameter int IDXW  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NWORD*WBITS-1:0]       status_i,
  input  logic [NLINE*NWORD*WBITS-1:0] mask_i,
  input  logic [SELW-1:0]              sel_i,
  output logic [NLINE-1:0]             irq_o,
  output logic [NLINE-1:0]             line_any_o,
  output logic                         vec_valid_o,
  output logic [IDXW-1:0]              vec_idx_o
);
  localparam int NEVT = NWORD * WBITS;

  // lowest set bit: {found, index}
  function automatic logic [IDXW:0] first_set(input logic [NEVT-1:0] v);
    logic [IDXW:0] r;
    r = '0;
    for (int i = NEVT - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDXW'(i)};
    end
    return r;
  endfunction

  logic [NEVT-1:0] pend [NLINE];
  logic [NEVT-1:0] sel_pend;
  logic [NLINE-1:0] irq_q;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    assign pend[l]       = status_i & mask_i[l*NEVT +: NEVT];
    assign line_any_o[l] = |pend[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_any_o;
  end
  assign irq_o = irq_q;

  always_comb begin
    sel_pend = '0;
    for (int l = 0; l < NLINE; l++) begin
      if (sel_i == SELW'(l)) sel_pend = pend[l];
    end
  end

  assign {vec_valid_o, vec_idx_o} = first_set(sel_pend);
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
  parameter int NLINE = 3,
  parameter int NWORD = 3,
  parameter int WBITS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWORD*WBITS-1:0] evt_i,
  input  logic [7:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [NLINE-1:0]       irq_o
);
  import evt_irq_pkg::*;
  localparam int NEVT  = NWORD * WBITS;
  localparam int GSPAN = NEVT;
  localparam int SELW  = $clog2(NLINE + 1);
  localparam int IDXW  = $clog2(NEVT);

  logic [NEVT-1:0]       status_flat;
  logic [NEVT-1:0]       clr_flat;
  logic [NLINE*NEVT-1:0] mask_flat;
  logic [NLINE-1:0]      line_any;
  logic                  vec_valid;
  logic [IDXW-1:0]       vec_idx;
  logic [SELW-1:0]       sel_q;
  logic                  sel_wr;

  evt_status_bank #(.NWORD(NWORD), .WBITS(WBITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(bus_wr),
    .wr_addr(bus_addr), .wr_data(bus_wdata[WBITS-1:0]),
    .status_o(status_flat), .clr_o(clr_flat));

  evt_mask_bank #(.NLINE(NLINE), .NWORD(NWORD), .WBITS(WBITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata[WBITS-1:0]), .mask_o(mask_flat));

  evt_line_resolver #(.NLINE(NLINE), .NWORD(NWORD), .WBITS(WBITS),
                      .SELW(SELW), .IDXW(IDXW)) u_res (
    .clk(clk), .rst_n(rst_n), .status_i(status_flat), .mask_i(mask_flat),
    .sel_i(sel_q), .irq_o(irq_o), .line_any_o(line_any),
    .vec_valid_o(vec_valid), .vec_idx_o(vec_idx));

  assign sel_wr = bus_wr && (bus_addr == SEL_ADDR);
  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= bus_wdata[SELW-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (bus_addr == stat_addr(w)) bus_rdata = 32'(status_flat[w*WBITS +: WBITS]);
    end
    for (int g = 0; g < NLINE; g++) begin
      for (int w = 0; w < NWORD; w++) begin
        if (bus_addr == mask_addr(g, w))
          bus_rdata = 32'(mask_flat[g*GSPAN + w*WBITS +: WBITS]);
      end
    end
    if (bus_addr == VEC_ADDR) bus_rdata = {vec_valid, {(31-IDXW){1'b0}}, vec_idx};
    if (bus_addr == SEL_ADDR) bus_rdata = 32'(sel_q);
  end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
  parameter int NLINE = 3,
  parameter int NWORD = 3,
  parameter int WBITS = 32,
  parameter int SELW  = 2,
  parameter int IDXW  = 7
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NWORD*WBITS-1:0]       evt_i,
  input logic [NWORD*WBITS-1:0]       status_flat,
  input logic [NWORD*WBITS-1:0]       clr_flat,
  input logic [NLINE*NWORD*WBITS-1:0] mask_flat,
  input logic [SELW-1:0]              sel_q,
  input logic                         vec_valid,
  input logic [IDXW-1:0]              vec_idx,
  input logic [NLINE-1:0]             irq_o
);
  localparam int NEVT = NWORD * WBITS;
  logic [NLINE-1:0] exp_any;
  logic [NEVT-1:0]  sel_pend;
  logic [NEVT-1:0]  below;

  always_comb begin
    sel_pend = '0;
    for (int g = 0; g < NLINE; g++) begin
      exp_any[g] = |(status_flat & mask_flat[g*NEVT +: NEVT]);
      if (sel_q == SELW'(g)) sel_pend = status_flat & mask_flat[g*NEVT +: NEVT];
    end
    below = ~({NEVT{1'b1}} << vec_idx);
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (irq_o == '0));
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> (($past(evt_i) & ~status_flat) == '0));
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_flat) & ~$past(clr_flat)) & ~status_flat) == '0));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_flat & ~evt_i) |=> (($past(clr_flat & ~evt_i) & status_flat) == '0));
  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_flat & evt_i) |=> (($past(clr_flat & evt_i) & ~status_flat) == '0));
  p_line_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(exp_any)));
  p_vec_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> sel_pend[vec_idx]);
  p_vec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((sel_pend & below) == '0));
  p_vec_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (sel_pend == '0));
endmodule

bind evt_irq_hub evt_irq_hub_chk #(
  .NLINE(NLINE), .NWORD(NWORD), .WBITS(WBITS), .SELW(SELW), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .status_flat(status_flat),
  .clr_flat(clr_flat), .mask_flat(mask_flat), .sel_q(sel_q),
  .vec_valid(vec_valid), .vec_idx(vec_idx), .irq_o(irq_o));

// File: tb/sim_evt_irq_hub.sv
module sim_evt_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  evt_irq_hub u0 (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #4 clk = ~clk;

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [31:0] st [3];
  logic [31:0] mk [3][3];
  logic [1:0]  sel_m;

  function automatic logic [2:0] model_irq();
    logic [2:0] r = '0;
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 3; w++)
        if ((st[w] & mk[g][w]) != 0) r[g] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] model_vec();
    if (sel_m == 2'd3) return 32'h0;
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 32; b++)
        if (st[w][b] && mk[sel_m][w][b]) return 32'h8000_0000 | 32'(w * 32 + b);
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a < 8'h0C && a[1:0] == 0) return st[a >> 2];
    if (a >= 8'h10 && a < 8'h40 && a[3:0] < 4'hC && a[1:0] == 0)
      return mk[(a >> 4) - 1][a[3:0] >> 2];
    if (a == 8'h40) return model_vec();
    if (a == 8'h44) return {30'b0, sel_m};
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [95:0] e);
    if (a < 8'h0C && a[1:0] == 0) st[a >> 2] = st[a >> 2] & ~d;
    else if (a >= 8'h10 && a < 8'h40 && a[3:0] < 4'hC && a[1:0] == 0)
      mk[(a >> 4) - 1][a[3:0] >> 2] = d;
    else if (a == 8'h44) sel_m = d[1:0];
    for (int w = 0; w < 3; w++) st[w] = st[w] | e[w*32 +: 32];
  endtask

  // driver tasks: one queued item per cycle at most
  task automatic exp_read(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 0; it.exp = model_read(a); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_irq(input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {29'b0, model_irq()}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [95:0] e, input bit do_wr);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = do_wr; evt_i = e;
    @(negedge clk);
    bus_wr = 1'b0; evt_i = '0;
    if (do_wr) model_write(a, d, e);
    else model_write(8'hFF, 32'h0, e);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_evt(a, d, '0, 1'b1);
  endtask

  task automatic pulse_lag(input logic [95:0] e);
    item_t it;
    @(negedge clk);
    evt_i = e;
    it.is_irq = 1; it.exp = {29'b0, model_irq()}; it.tag = "R6 lag";
    q.push_back(it);
    @(negedge clk);
    evt_i = '0;
    model_write(8'hFF, 32'h0, e);
  endtask

  // monitor: compares away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {29'b0, irq_o} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) begin
      st[w] = '0;
      for (int g = 0; g < 3; g++) mk[g][w] = '0;
    end
    sel_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    exp_read(8'h00, "R1 status0"); exp_read(8'h08, "R1 status2");
    exp_read(8'h24, "R1 mask"); exp_read(8'h40, "R1 vector");
    exp_read(8'h44, "R1 selector"); exp_irq("R1 irq");
    // R2 latch and hold, R6 lag on the setting edge
    pulse_lag(96'h1 << 5);
    exp_read(8'h00, "R2 word0");
    wr_evt(8'h00, 32'h0, (96'h1 << 40) | (96'h1 << 95), 1'b0);
    repeat (4) @(negedge clk);
    exp_read(8'h04, "R2 word1 held"); exp_read(8'h08, "R2 word2 held");
    exp_irq("R6 masked off");
    // R5 mask r/w, R6 line
    wr(8'h24, 32'h100);
    exp_irq("R6 group1 up");
    exp_read(8'h24, "R5 readback");
    wr(8'h38, 32'hDEAD_BEEF);
    exp_read(8'h38, "R5 group2 word2");
    exp_irq("R6 group2 up");
    wr(8'h38, 32'h0);
    // R8 vector
    wr(8'h44, 32'h1);
    exp_read(8'h44, "R10 selector readback");
    exp_read(8'h40, "R8 vec 40");
    wr(8'h20, 32'h20); wr(8'h28, 32'h8000_0000);
    exp_read(8'h40, "R8 vec lowest 5");
    // R3 write-one-to-clear
    wr(8'h00, 32'h20);
    exp_read(8'h00, "R3 cleared");
    exp_read(8'h40, "R8 vec next 40");
    wr(8'h04, 32'h0);
    exp_read(8'h04, "R3 zero write keeps");
    // R7 mask clear keeps status
    wr(8'h24, 32'h0);
    exp_read(8'h04, "R7 status kept");
    exp_read(8'h40, "R7 vec skips 40");
    exp_irq("R7 line");
    // R4 collision
    wr_evt(8'h08, 32'h8000_0000, 96'h1 << 95, 1'b1);
    exp_read(8'h08, "R4 event wins");
    wr(8'h08, 32'h8000_0000);
    exp_read(8'h08, "R3 word2 cleared");
    exp_irq("R6 group1 down");
    exp_read(8'h40, "R9 empty line");
    // R9 selector 3
    wr(8'h10, 32'h1);
    pulse_lag(96'h1);
    wr(8'h44, 32'h3);
    exp_read(8'h40, "R9 sel3");
    wr(8'h44, 32'h0);
    exp_read(8'h40, "R8 vec group0 ev0");
    wr(8'h30, 32'hFFFF_FFFF);
    exp_irq("R6 groups 0 and 2");
    // R10 unmapped
    exp_read(8'h0C, "R10 0x0C"); exp_read(8'h3C, "R10 0x3C");
    exp_read(8'h48, "R10 0x48"); exp_read(8'h02, "R10 0x02");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule